// File: doc/BRIEF.md
# CAN Bus-Off Recovery Monitor

This block watches a CAN controller's transmit and receive error counters and reduces them to a single error level: error-active, error-warning, error-passive or bus-off. The level is reported as three flag bits inside a 32-bit status word. The same word also carries the two counters. Every change of level raises a one-cycle event. The block does not compute the counters itself and does not handle bit timing. It only consumes the counter values and a per-bit sample strobe that come from the protocol engine.

Bus-off is sticky, and the counters alone cannot clear it. Software must first enter reset mode and then leave it. After that, the monitor counts idle conditions on the bus. An idle condition is a run of consecutive recessive sampled bits. Once enough idle conditions have been seen, the monitor asks the transmit queue to flush the frames it flagged for abort when bus-off began. The drain request is a valid/ready pair: `drain_valid` rises and stays high until the queue answers with `drain_ready` in the same cycle. The queue may hold `drain_ready` low for as long as it needs, and nothing else moves during that time. When the handshake completes, the monitor returns to error-active, raises the event and pulses a clear for the counter logic.

Top module: `can_busoff_monitor`

## Requirements
- R1: Outside bus-off, the level follows the counters with this priority: bus-off when the transmit count exceeds 255, else passive when either count is at least 128, else warning when either count is at least 96, else active. Status bit 19 flags bus-off, bit 18 flags passive and bit 17 flags warning. At most one of these bits is set, and all three are clear in active. The bits update one clock after the counters are sampled.
- R2: Status bits [7:0] show the receive count and bits [15:8] show the transmit count, both combinationally from the inputs. A transmit count above 255 shows as 255.
- R3: On the clock where bus-off is entered, `abort_all` pulses for exactly one cycle.
- R4: Once bus-off is set, it stays set whatever the counters do, until the drain handshake completes.
- R5: Idle counting starts only after `reset_mode` has been seen high and then low while in bus-off. If `reset_mode` is raised again during counting, the monitor discards all progress and waits for the next release.
- R6: An idle condition is 11 consecutive strobed bits with `bus_rec` = 1 (recessive). Cycles with `bit_stb` low are ignored. A strobed dominant bit (`bus_rec` = 0) restarts the current run but keeps the idle conditions already completed.
- R7: `drain_valid` rises one clock after the 128th idle condition completes. It stays high while `drain_ready` is low. It is never high before that point.
- R8: The cycle after `drain_valid` and `drain_ready` are both high, the level is active, and `cnt_clear` and `state_evt` are each high for one cycle.
- R9: `state_evt` is high for exactly one cycle after each clock on which the reported level changed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe for each sampled bus bit |
| bus_rec | input | 1 | Sampled bus level, 1 = recessive |
| tx_err_cnt | input | 9 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| reset_mode | input | 1 | Controller reset-mode control from software |
| status_word | output | 32 | Level flags (bits 19..17) and counters ([15:8] transmit, [7:0] receive) |
| state_evt | output | 1 | One-cycle pulse on a level change |
| abort_all | output | 1 | One-cycle pulse flagging every pending transmit slot for abort |
| drain_valid | output | 1 | Request to flush aborted queue entries |
| drain_ready | input | 1 | Queue accepts the drain request |
| cnt_clear | output | 1 | One-cycle pulse telling the counter logic to zero both counters |

## Verification
Two things coincide when recovery ends. The drain handshake completes, and on that same clock the level falls from bus-off to active. The counter clear and the state event must therefore appear together in one cycle. The bench first holds `drain_ready` low for several cycles and confirms the request holds steady. It then raises `drain_ready` and checks the level flags, `cnt_clear` and `state_evt` in the single sample after that edge, and checks that all pulses are gone one cycle later. A second overlap is a dominant bit arriving in the middle of a run after many completed idle conditions. The bench shows that exactly one further full run, and not a full restart, raises the drain request.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;

  typedef enum logic [1:0] {
    LVL_ACTIVE  = 2'd0,
    LVL_WARN    = 2'd1,
    LVL_PASSIVE = 2'd2,
    LVL_BUSOFF  = 2'd3
  } err_level_t;

  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_WARN     = 3'd1,
    ST_PASSIVE  = 3'd2,
    ST_BO_WAIT  = 3'd3,
    ST_BO_HELD  = 3'd4,
    ST_BO_COUNT = 3'd5,
    ST_BO_DRAIN = 3'd6
  } mon_state_t;

  function automatic err_level_t level_of(mon_state_t s);
    case (s)
      ST_ACTIVE:  return LVL_ACTIVE;
      ST_WARN:    return LVL_WARN;
      ST_PASSIVE: return LVL_PASSIVE;
      default:    return LVL_BUSOFF;
    endcase
  endfunction

endpackage

// File: rtl/can_err_classify.sv
module can_err_classify
  import can_bo_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BO_LIM   = 256
) (
  input  logic [TEC_W-1:0] tec,
  input  logic [REC_W-1:0] rec,
  output err_level_t       lvl
);

  logic is_bo, is_pass, is_warn;

  // Thresholds compared in 32-bit space so any counter width works
  assign is_bo   = int'(tec) >= BO_LIM;
  assign is_pass = (int'(tec) >= PASS_LIM) || (int'(rec) >= PASS_LIM);
  assign is_warn = (int'(tec) >= WARN_LIM) || (int'(rec) >= WARN_LIM);

  always_comb begin
    if (is_bo)        lvl = LVL_BUSOFF;
    else if (is_pass) lvl = LVL_PASSIVE;
    else if (is_warn) lvl = LVL_WARN;
    else              lvl = LVL_ACTIVE;
  end

endmodule

// File: rtl/can_idle_counter.sv
module can_idle_counter #(
  parameter int RUN_LEN   = 11,
  parameter int IDLE_NEED = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_stb,
  input  logic bit_rec,
  output logic idle_done
);

  localparam int RUN_W  = $clog2(RUN_LEN);
  localparam int IDLE_W = $clog2(IDLE_NEED + 1);

  logic [RUN_W-1:0]  run_q;
  logic [IDLE_W-1:0] idle_q;
  logic              run_end;

  assign run_end   = run_q == RUN_W'(RUN_LEN - 1);
  assign idle_done = idle_q == IDLE_W'(IDLE_NEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= '0;
    end else if (!en) begin
      run_q  <= '0;
      idle_q <= '0;
    end else if (bit_stb) begin
      if (!bit_rec) begin
        run_q <= '0;                       // dominant: restart the run only
      end else if (run_end) begin
        run_q <= '0;
        if (!idle_done) idle_q <= idle_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_RUN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) < RUN_LEN); // R6

  AST_DOMINANT_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_stb && !bit_rec) |=> (idle_q == $past(idle_q))); // R6

  AST_IDLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idle_q) <= IDLE_NEED); // R7

endmodule

// File: rtl/can_busoff_monitor.sv
module can_busoff_monitor
  import can_bo_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 128,
  parameter int BO_LIM    = 256,
  parameter int RUN_LEN   = 11,
  parameter int IDLE_NEED = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bus_rec,
  input  logic [TEC_W-1:0] tx_err_cnt,
  input  logic [REC_W-1:0] rx_err_cnt,
  input  logic             reset_mode,
  output logic [31:0]      status_word,
  output logic             state_evt,
  output logic             abort_all,
  output logic             drain_valid,
  input  logic             drain_ready,
  output logic             cnt_clear
);

  localparam int FLAG_WARN = 17;
  localparam int FLAG_PASS = 18;
  localparam int FLAG_BO   = 19;

  mon_state_t st_q, st_d;
  err_level_t cls_lvl, cur_lvl, nxt_lvl;
  logic       idle_done;
  logic       drain_fire;
  logic [7:0] tec_field, rec_field;

  can_err_classify #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM), .BO_LIM(BO_LIM)
  ) u_classify (
    .tec(tx_err_cnt),
    .rec(rx_err_cnt),
    .lvl(cls_lvl)
  );

  can_idle_counter #(.RUN_LEN(RUN_LEN), .IDLE_NEED(IDLE_NEED)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (st_q == ST_BO_COUNT),
    .bit_stb  (bit_stb),
    .bit_rec  (bus_rec),
    .idle_done(idle_done)
  );

  assign drain_valid = (st_q == ST_BO_DRAIN);
  assign drain_fire  = drain_valid && drain_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_ACTIVE, ST_WARN, ST_PASSIVE: begin
        case (cls_lvl)
          LVL_BUSOFF:  st_d = ST_BO_WAIT;
          LVL_PASSIVE: st_d = ST_PASSIVE;
          LVL_WARN:    st_d = ST_WARN;
          default:     st_d = ST_ACTIVE;
        endcase
      end
      ST_BO_WAIT:  if (reset_mode)  st_d = ST_BO_HELD;
      ST_BO_HELD:  if (!reset_mode) st_d = ST_BO_COUNT;
      ST_BO_COUNT: begin
        if (reset_mode)     st_d = ST_BO_HELD;
        else if (idle_done) st_d = ST_BO_DRAIN;
      end
      ST_BO_DRAIN: if (drain_ready) st_d = ST_ACTIVE;
      default:     st_d = ST_ACTIVE;
    endcase
  end

  assign cur_lvl = level_of(st_q);
  assign nxt_lvl = level_of(st_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_ACTIVE;
      state_evt <= 1'b0;
      abort_all <= 1'b0;
      cnt_clear <= 1'b0;
    end else begin
      st_q      <= st_d;
      state_evt <= (nxt_lvl != cur_lvl);
      abort_all <= (nxt_lvl == LVL_BUSOFF) && (cur_lvl != LVL_BUSOFF);
      cnt_clear <= drain_fire;
    end
  end

  assign tec_field = (int'(tx_err_cnt) > 255) ? 8'hFF : 8'(tx_err_cnt);
  assign rec_field = (int'(rx_err_cnt) > 255) ? 8'hFF : 8'(rx_err_cnt);

  always_comb begin
    status_word            = '0;
    status_word[7:0]       = rec_field;
    status_word[15:8]      = tec_field;
    status_word[FLAG_WARN] = (cur_lvl == LVL_WARN);
    status_word[FLAG_PASS] = (cur_lvl == LVL_PASSIVE);
    status_word[FLAG_BO]   = (cur_lvl == LVL_BUSOFF);
  end

  AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_word[FLAG_BO:FLAG_WARN])); // R1

  AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_all |-> $rose(status_word[FLAG_BO])); // R3

  AST_BUSOFF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[FLAG_BO] && !drain_fire) |=> status_word[FLAG_BO]); // R4

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=> drain_valid); // R7

  AST_CLEAR_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |-> (state_evt && (status_word[FLAG_BO:FLAG_WARN] == 3'b000))); // R8

endmodule

// File: tb/can_busoff_monitor_test.sv
module can_busoff_monitor_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_stb;
  logic        bus_rec;
  logic [8:0]  tx_err_cnt;
  logic [7:0]  rx_err_cnt;
  logic        reset_mode;
  logic [31:0] status_word;
  logic        state_evt;
  logic        abort_all;
  logic        drain_valid;
  logic        drain_ready;
  logic        cnt_clear;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_busoff_monitor uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bus_rec(bus_rec),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .reset_mode(reset_mode),
    .status_word(status_word), .state_evt(state_evt), .abort_all(abort_all),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .cnt_clear(cnt_clear)
  );

  // Expected level flags {bo, passive, warn} from the counters
  function automatic logic [2:0] exp_flags(int tec, int rec);
    if (tec > 255)                    return 3'b100;
    if (tec >= 128 || rec >= 128)     return 3'b010;
    if (tec >= 96  || rec >= 96)      return 3'b001;
    return 3'b000;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(logic rec);
    bit_stb = 1'b1;
    bus_rec = rec;
    step();
    bit_stb = 1'b0;
  endtask

  // One idle condition, with strobe-free dominant gap cycles mixed in
  task automatic send_run(bit gaps);
    for (int i = 0; i < 11; i++) begin
      send_bit(1'b1);
      if (gaps && (i % 4 == 1)) begin
        bus_rec = 1'b0;
        step();
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev_flags, cur_exp;
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; bit_stb = 1'b0; bus_rec = 1'b1;
    tx_err_cnt = '0; rx_err_cnt = '0; reset_mode = 1'b0; drain_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    chk(status_word[19:17] == 3'b000, "R1 reset level", int'(status_word[19:17]), 0);
    chk(!drain_valid && !state_evt && !abort_all && !cnt_clear, "R9 reset pulses",
        int'({drain_valid, state_evt, abort_all, cnt_clear}), 0);

    // Random counters below bus-off, biased toward the thresholds
    prev_flags = 3'b000;
    for (int n = 0; n < 300; n++) begin
      int t, r;
      t = int'($urandom % 256);
      r = int'($urandom % 256);
      if (n % 3 == 0) t = 94 + int'($urandom % 4);
      if (n % 5 == 0) r = 126 + int'($urandom % 4);
      tx_err_cnt = 9'(t);
      rx_err_cnt = 8'(r);
      #1;
      chk(status_word[7:0] == 8'(r) && status_word[15:8] == 8'(t), "R2 counter fields",
          int'(status_word[15:0]), (t << 8) | r);
      step();
      cur_exp = exp_flags(t, r);
      chk(status_word[19:17] == cur_exp, "R1 level flags", int'(status_word[19:17]), int'(cur_exp));
      chk(state_evt == (cur_exp != prev_flags), "R9 event pulse", int'(state_evt),
          int'(cur_exp != prev_flags));
      prev_flags = cur_exp;
    end

    // Boundary: 255 is not bus-off
    tx_err_cnt = 9'd255; rx_err_cnt = 8'd0;
    step(); step();
    chk(status_word[19:17] == 3'b010, "R1 tec 255 passive", int'(status_word[19:17]), 2);

    // Bus-off entry
    tx_err_cnt = 9'd256;
    #1;
    chk(status_word[15:8] == 8'hFF, "R2 saturated tec", int'(status_word[15:8]), 255);
    step();
    chk(status_word[19:17] == 3'b100, "R1 busoff flag", int'(status_word[19:17]), 4);
    chk(abort_all == 1'b1, "R3 abort pulse", int'(abort_all), 1);
    chk(state_evt == 1'b1, "R9 event on busoff", int'(state_evt), 1);
    step();
    chk(abort_all == 1'b0, "R3 abort single cycle", int'(abort_all), 0);
    chk(state_evt == 1'b0, "R9 event single cycle", int'(state_evt), 0);

    // Counters cleared externally: bus-off must remain
    tx_err_cnt = '0; rx_err_cnt = '0;
    repeat (3) step();
    chk(status_word[19] == 1'b1, "R4 busoff latched", int'(status_word[19]), 1);

    // Idle bits without a reset-mode cycle do nothing
    for (int k = 0; k < 130; k++) send_run(1'b0);
    step();
    chk(!drain_valid && status_word[19], "R5 no count without reset release",
        int'(drain_valid), 0);

    // Reset-mode cycle starts counting; a second one restarts it
    reset_mode = 1'b1; step();
    reset_mode = 1'b0; step();
    for (int k = 0; k < 50; k++) send_run(1'b0);
    reset_mode = 1'b1; step();
    reset_mode = 1'b0; step();
    for (int k = 0; k < 127; k++) send_run(k % 7 == 0);
    step();
    chk(drain_valid == 1'b0, "R5 restart discards progress", int'(drain_valid), 0);

    // Partial run broken by a dominant bit, then a full run
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b0);
    bus_rec = 1'b0; step();
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    step();
    chk(drain_valid == 1'b0, "R6 ten recessive bits not enough", int'(drain_valid), 0);
    send_bit(1'b1);
    step();
    chk(drain_valid == 1'b1, "R7 drain after 128 idles", int'(drain_valid), 1);
    chk(status_word[19] == 1'b1, "R4 busoff during drain", int'(status_word[19]), 1);

    // Back-pressure on the drain request
    for (int i = 0; i < 3; i++) begin
      step();
      chk(drain_valid == 1'b1, "R7 drain held", int'(drain_valid), 1);
    end

    drain_ready = 1'b1;
    step();
    drain_ready = 1'b0;
    chk(status_word[19:17] == 3'b000, "R8 active after drain", int'(status_word[19:17]), 0);
    chk(cnt_clear == 1'b1, "R8 counter clear", int'(cnt_clear), 1);
    chk(state_evt == 1'b1, "R8 recovery event", int'(state_evt), 1);
    chk(drain_valid == 1'b0, "R7 drain dropped", int'(drain_valid), 0);
    step();
    chk(cnt_clear == 1'b0 && state_evt == 1'b0, "R9 pulses end",
        int'({cnt_clear, state_evt}), 0);
    chk(status_word[19:17] == 3'b000, "R1 stays active", int'(status_word[19:17]), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule